// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a bus-attached watchdog. A 32-bit countdown is reloaded by software through a timer register, and every such write is the keepalive. A control register picks what expiry does: nothing, a single-cycle interrupt pulse, a single-cycle non-maskable interrupt pulse, or a chip-reset request held for a fixed number of cycles. The same control register carries a read-only flag that tells software whether the previous reset came from the watchdog.

A timer write does not reach the countdown at once. It passes through a short load pipeline of `LOAD_LAT` cycles, and until then the old count keeps running. The countdown only moves while an action is selected. Once it reaches zero it fires at most once and stays at zero until the next reload. The last-reset flag lives in a separate power-on domain. A system reset leaves the flag as it is. Only the power-on reset clears it.

Top module: `wdt_sentinel`

## Requirements
- R1: After reset the action field reads 0, the timer register reads 0xFFFFFFFF, all three outputs are low, and after a power-on reset the last-reset flag (control bit 31) reads 0.
- R2: The control register sits at offset 0x0 with the action in bits [1:0] (0 off, 1 interrupt, 2 NMI, 3 chip reset) and the last-reset flag in bit 31, which writes cannot change. All other control bits read 0. The timer register sits at offset 0x4. Any other offset reads 0, and writes to it change nothing.
- R3: A timer write takes effect exactly `LOAD_LAT` clock edges after the edge that captures it. Until then the timer register reads back the previous count.
- R4: While the action is non-zero the count drops by one per clock. While the action is 0 the count holds its value.
- R5: When the count is zero it stays zero until a reload, and the selected action fires exactly once.
- R6: With action 1, `irq_pulse` is high for exactly one cycle, on the cycle after the timer first reads zero. The other outputs stay low.
- R7: With action 2, `nmi_pulse` is high for exactly one cycle, on the cycle after the timer first reads zero.
- R8: With action 3, `chip_rst_req` is high for exactly `RST_HOLD` consecutive cycles, starting on the cycle after the timer first reads zero.
- R9: A chip-reset expiry sets the last-reset flag. The flag stays set through a system reset (`rst_n`) and is cleared only by `por_n`.
- R10: With action 0 no expiry produces any output, including when a zero count is held.
- R11: Reloading the timer before it reaches zero keeps the action from firing.
- R12: Loading zero re-arms the expiry, so with a non-zero action the selected output fires on the cycle after the action becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, asynchronous active-low, released synchronously |
| por_n | input | 1 | Power-on reset, asynchronous active-low; also clears the last-reset flag |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (1 write, 0 read) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| irq_pulse | output | 1 | Single-cycle interrupt on expiry (action 1) |
| nmi_pulse | output | 1 | Single-cycle NMI on expiry (action 2) |
| chip_rst_req | output | 1 | Chip-reset request held RST_HOLD cycles (action 3) |

## Verification
The bench builds the block with `LOAD_LAT` of 3 and `RST_HOLD` of 16. With these values it can count every cycle of the load pipeline and the whole reset-request window. It uses loads of zero to a few counts, so expiry, the fire-once rule and zero-load re-arming are all reached within a few dozen cycles. A full countdown from 0xFFFFFFFF is out of reach. Instead, the bench checks that the reset value is held while the action is off and only starts to count down once an action is enabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_DATA_W    = 32;
  localparam int unsigned WDT_CTRL_OFS  = 0;
  localparam int unsigned WDT_TIMER_OFS = 4;
  localparam int unsigned WDT_FLAG_BIT  = WDT_DATA_W - 1;

  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_IRQ = 2'd1,
    ACT_NMI = 2'd2,
    ACT_RST = 2'd3
  } wdt_act_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WDT_DATA_W-1:0] bus_wdata,
  output logic [WDT_DATA_W-1:0] bus_rdata,
  input  logic                  flag,
  input  logic [CNT_W-1:0]      cnt,
  output wdt_act_e              act,
  output logic                  ld_req,
  output logic [CNT_W-1:0]      ld_val
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(WDT_CTRL_OFS);
  localparam logic [ADDR_W-1:0] TIMER_A = ADDR_W'(WDT_TIMER_OFS);

  logic     hit_ctrl, hit_timer;
  wdt_act_e act_q, act_d;

  assign hit_ctrl  = bus_sel && (bus_addr == CTRL_A);
  assign hit_timer = bus_sel && (bus_addr == TIMER_A);

  always_comb begin
    act_d = act_q;
    if (hit_ctrl && bus_wr) act_d = wdt_act_e'(bus_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= ACT_OFF;
    else        act_q <= act_d;
  end

  assign act    = act_q;
  assign ld_req = hit_timer && bus_wr;
  assign ld_val = bus_wdata[CNT_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[1:0]          = act_q;
      bus_rdata[WDT_FLAG_BIT] = flag;
    end else if (hit_timer) begin
      bus_rdata[CNT_W-1:0] = cnt;
    end
  end

  // R2: writes that miss the control register leave the action unchanged
  p_stray_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !hit_ctrl) |=> (act_q == $past(act_q)));
  // R2: a control write lands in the action field on the next cycle
  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && bus_wr) |=> (act_q == $past(bus_wdata[1:0])));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOAD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_en,
  input  logic             ld_req,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam int unsigned LAST = LOAD_LAT - 1;

  logic             stg_v [LOAD_LAT];
  logic [CNT_W-1:0] stg_d [LOAD_LAT];

  for (genvar s = 0; s < LOAD_LAT; s++) begin : g_stage
    logic             v_in;
    logic [CNT_W-1:0] d_in;
    if (s == 0) begin : g_head
      assign v_in = ld_req;
      assign d_in = ld_val;
    end else begin : g_body
      assign v_in = stg_v[s-1];
      assign d_in = stg_d[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_v[s] <= 1'b0;
      else        stg_v[s] <= v_in;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stg_d[s] <= '0;
      else if (v_in) stg_d[s] <= d_in;
    end
  end

  logic             ld_arrive;
  logic [CNT_W-1:0] ld_data;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  assign ld_arrive = stg_v[LAST];
  assign ld_data   = stg_d[LAST];

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    expire  = 1'b0;
    if (ld_arrive) begin
      cnt_d   = ld_data;
      armed_d = 1'b1;
    end else if (act_en) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (armed_q) begin
        expire  = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      armed_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt = cnt_q;

  // R3: a value leaving the load pipeline becomes the count
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_arrive |=> (cnt_q == $past(ld_data)));
  // R4: the count holds while the action is off
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en && !ld_arrive) |=> (cnt_q == $past(cnt_q)));
  // R4: one step down per cycle while enabled
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !ld_arrive && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R5: zero is sticky until a reload
  p_zero_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ld_arrive) |=> (cnt_q == '0));
  // R5: expiry never repeats without a reload in between
  p_fire_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/wdt_response.sv
module wdt_response
  import wdt_pkg::*;
#(
  parameter int unsigned RST_HOLD = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     por_n,
  input  logic     expire,
  input  wdt_act_e act,
  output logic     irq,
  output logic     nmi,
  output logic     rst_req,
  output logic     last_wdt_rst
);
  localparam int unsigned HOLD_W = $clog2(RST_HOLD + 1);
  localparam int unsigned CHK_W  = HOLD_W + 1;

  logic              irq_q, irq_d, nmi_q, nmi_d;
  logic              fire_rst;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              flag_q, flag_d;

  always_comb begin
    irq_d    = expire && (act == ACT_IRQ);
    nmi_d    = expire && (act == ACT_NMI);
    fire_rst = expire && (act == ACT_RST);
    hold_d   = hold_q;
    if (fire_rst)            hold_d = HOLD_W'(RST_HOLD);
    else if (hold_q != '0)   hold_d = hold_q - HOLD_W'(1);
    flag_d   = flag_q | fire_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      irq_q  <= irq_d;
      nmi_q  <= nmi_d;
      hold_q <= hold_d;
    end
  end

  // power-on domain: survives a system reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq          = irq_q;
  assign nmi          = nmi_q;
  assign rst_req      = (hold_q != '0);
  assign last_wdt_rst = flag_q;

  // checker: length of the current reset-request window
  logic [CHK_W-1:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_len <= '0;
    else if (rst_req) chk_len <= chk_len + CHK_W'(1);
    else              chk_len <= '0;
  end

  // R6: interrupt is a single-cycle pulse
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R7: NMI is a single-cycle pulse
  p_nmi_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |=> !nmi_q);
  // R6: at most one pulse output at a time
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, nmi_q}));
  // R8: request window lasts exactly RST_HOLD cycles
  p_req_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (chk_len == CHK_W'(RST_HOLD)));
  // R9: a reset expiry records itself in the flag
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rst |=> flag_q);
  // R9: only power-on reset may clear the flag
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(flag_q));
endmodule

// File: rtl/wdt_sentinel.sv
module wdt_sentinel
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned LOAD_LAT    = 3,
  parameter int unsigned RST_HOLD    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse,
  output logic              nmi_pulse,
  output logic              chip_rst_req
);
  logic             sys_arst_n, sys_rst_n, por_rst_n;
  wdt_act_e         act;
  logic             ld_req, expire, flag;
  logic [CNT_W-1:0] ld_val, cnt;

  assign sys_arst_n = rst_n & por_n;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(clk), .arst_n(sys_arst_n), .srst_n(sys_rst_n)
  );

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_rst_n)
  );

  wdt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst_n(sys_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag(flag), .cnt(cnt), .act(act),
    .ld_req(ld_req), .ld_val(ld_val)
  );

  wdt_countdown #(.CNT_W(CNT_W), .LOAD_LAT(LOAD_LAT)) u_count (
    .clk(clk), .rst_n(sys_rst_n), .act_en(act != ACT_OFF),
    .ld_req(ld_req), .ld_val(ld_val), .cnt(cnt), .expire(expire)
  );

  wdt_response #(.RST_HOLD(RST_HOLD)) u_resp (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_rst_n),
    .expire(expire), .act(act),
    .irq(irq_pulse), .nmi(nmi_pulse), .rst_req(chip_rst_req),
    .last_wdt_rst(flag)
  );
endmodule

// File: tb/tb_wdt_sentinel.sv
module tb_wdt_sentinel;
  localparam int LAT  = 3;
  localparam int HOLD = 16;
  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_TIMER = 4'h4;
  localparam logic [3:0] A_NONE  = 4'h8;
  localparam int NVEC = 7;
  // {action[1:0], load[31:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd1, 32'd5}, {2'd2, 32'd3}, {2'd3, 32'd4}, {2'd0, 32'd6},
    {2'd1, 32'd0}, {2'd2, 32'd0}, {2'd3, 32'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n, por_n, bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_pulse, nmi_pulse, chip_rst_req;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdt_sentinel #(.ADDR_W(4), .CNT_W(32), .LOAD_LAT(LAT), .RST_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse), .chip_rst_req(chip_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, old;
    int quiet;
    rst_n = 1'b0; por_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(5);
    rst_n = 1'b1; por_n = 1'b1;
    idle(4);

    // R1: reset values
    rd(A_CTRL, v);  chk("R1 ctrl after por", v, 32'h0);
    rd(A_TIMER, v); chk("R1 timer after por", v, 32'hFFFF_FFFF);
    chk("R1 outputs low", {29'b0, irq_pulse, nmi_pulse, chip_rst_req}, 32'h0);

    // R2: unmapped offset
    wr(A_NONE, 32'h3);
    rd(A_CTRL, v);  chk("R2 stray write ctrl", v, 32'h0);
    rd(A_TIMER, v); chk("R2 stray write timer", v, 32'hFFFF_FFFF);
    rd(A_NONE, v);  chk("R2 unmapped read", v, 32'h0);
    // R2: bit 31 not writable, only [1:0] stored
    wr(A_CTRL, 32'hFFFF_FFFD);
    rd(A_CTRL, v);  chk("R2 ctrl field mask", v, 32'h1);
    wr(A_CTRL, 32'h0);

    // R3: load latency
    rd(A_TIMER, old);
    wr(A_TIMER, 32'd100);
    rd(A_TIMER, v); chk("R3 old count at write", v, old);
    idle(LAT - 1);
    rd(A_TIMER, v); chk("R3 old count before latency", v, old);
    idle(1);
    rd(A_TIMER, v); chk("R3 new count after latency", v, 32'd100);

    // R4: countdown while enabled, hold while off
    wr(A_CTRL, 32'h1);
    idle(10);
    rd(A_TIMER, v); chk("R4 ten steps down", v, 32'd90);
    wr(A_CTRL, 32'h0);
    rd(A_TIMER, old); chk("R4 stop value", old, 32'd88);
    idle(5);
    rd(A_TIMER, v); chk("R4 R10 held while off", v, old);

    // R11: periodic reloads prevent expiry
    wr(A_TIMER, 32'd20);
    idle(LAT + 2);
    wr(A_CTRL, 32'h1);
    quiet = 0;
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (irq_pulse) quiet++;
      end
      wr(A_TIMER, 32'd20);
    end
    chk("R11 no irq under keepalive", quiet, 0);
    wr(A_CTRL, 32'h0);

    // R10: armed zero with action off stays silent
    wr(A_TIMER, 32'd0);
    quiet = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (irq_pulse || nmi_pulse || chip_rst_req) quiet++;
    end
    chk("R10 no output when off", quiet, 0);
    rd(A_TIMER, v); chk("R10 zero held", v, 32'h0);

    // table-driven expiry vectors (load 0 rows cover R12)
    for (int vi = 0; vi < NVEC; vi++) begin
      logic [1:0]  va;
      logic [31:0] vv;
      int bad_irq, bad_nmi, bad_req;
      va = VEC[vi][33:32];
      vv = VEC[vi][31:0];
      bad_irq = 0; bad_nmi = 0; bad_req = 0;
      wr(A_CTRL, 32'h0);
      wr(A_TIMER, vv);
      idle(LAT + 2);
      wr(A_CTRL, {30'b0, va});
      for (int k = 1; k <= int'(vv) + HOLD + 4; k++) begin
        logic ei, en, er;
        @(negedge clk);
        ei = (va == 2'd1) && (k == int'(vv) + 1);
        en = (va == 2'd2) && (k == int'(vv) + 1);
        er = (va == 2'd3) && (k >= int'(vv) + 1) && (k <= int'(vv) + HOLD);
        if (irq_pulse !== ei) bad_irq++;
        if (nmi_pulse !== en) bad_nmi++;
        if (chip_rst_req !== er) bad_req++;
      end
      chk($sformatf("R6 R12 irq pattern vec %0d", vi), bad_irq, 0);
      chk($sformatf("R7 R12 nmi pattern vec %0d", vi), bad_nmi, 0);
      chk($sformatf("R8 req window vec %0d", vi), bad_req, 0);
      rd(A_TIMER, v);
      chk($sformatf("R5 R10 final count vec %0d", vi), v, (va == 2'd0) ? vv : 32'h0);
    end

    // R9: flag set, survives system reset, cleared by power-on reset
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R9 flag set after reset expiry", v, 32'h8000_0000);
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rd(A_CTRL, v);  chk("R9 flag kept over system reset", v, 32'h8000_0000);
    rd(A_TIMER, v); chk("R1 timer after system reset", v, 32'hFFFF_FFFF);
    por_n = 1'b0;
    idle(3);
    por_n = 1'b1;
    idle(4);
    rd(A_CTRL, v); chk("R9 flag cleared by por", v, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule